// File: doc/BRIEF.md
# Calibrated Real-Time Clock Core

This block keeps wall-clock time as a 32-bit count of elapsed seconds. An enable input pulses once per crystal period. A tick counter turns those pulses into one-second strobes, and each strobe advances the seconds counter. The second's length is set by software as an integer number of ticks. A small fractional trim stretches chosen seconds by one tick inside every 16-second window, which cancels a static crystal frequency error to a resolution of one tick per 16 seconds. That resolution is below 2 ppm with a 32768 Hz crystal and below 1 ppm with a 65536 Hz crystal.

Software reaches the block through a flat register port. Writes are single-cycle and reads are combinational. Through this port software can:
- load the seconds count;
- program an alarm value anywhere in the 32-bit range;
- enable two interrupt sources, one per second and one for the alarm, whose status bits are sticky and are cleared by writing one.

A test-mode bit disconnects the crystal input. Each write to a dedicated register then advances the counters by exactly one tick, so alarm paths can be exercised without waiting real time.

Top module: `rtc_core`

## Requirements
- R1: With calibration integer field I and fractional field 0, exactly I+1 accepted ticks separate consecutive increments of the seconds counter (register 0).
- R2: The seconds counter is 32 bits wide, wraps from 0xFFFFFFFF to 0, and a write to register 0 loads it with the written value on the next clock edge.
- R3: With fractional field N (register 2 bits [19:16], integer field in bits [15:0]), the second with window index k (0..15, counted from the last load) lasts I+2 ticks when k < N and I+1 ticks otherwise.
- R4: A write to the seconds register restarts the tick count and the 16-second index, so the next increment comes a full I+1 (or I+2 at index 0 when N>0) ticks after the write.
- R5: Status register 4 bit 0 sets on every seconds increment and stays set until software writes 1 to it. A set in the same cycle as the clear wins.
- R6: The output irq is high exactly when some status bit is set and its enable bit is set. Register 3 bit 0 enables the seconds source and bit 1 enables the alarm source.
- R7: Status bit 1 sets when the seconds counter increments to the alarm value in register 1, including the wrap to 0. Loading the seconds register with the alarm value does not set it.
- R8: While register 3 bit 2 is set, crystal tick pulses are ignored and each write to register 5 supplies exactly one tick. While bit 2 is clear, writes to register 5 have no effect.
- R9: Registers 1, 2 and 3 read back the last value written. After reset, register 2 holds integer field 32767 with fractional field 0, and registers 0, 1, 3 and 4 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_tick | input | 1 | One-cycle pulse per crystal period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | OR of enabled sticky status bits |

## Verification
A tick pulse or register write that is presented in one cycle takes effect at the following rising edge. Its results appear after that edge, namely the seconds count, the status bits and irq, which is a combinational function of registered state. The bench changes inputs only on falling edges. It reads registers half a cycle after the edge that applied the stimulus, so every result is sampled one edge after its cause. The calibration sweep counts ticks one at a time and reads the seconds register after each tick. This places every second boundary on the exact tick predicted by I+1+(k<N).

// File: rtl/rtc_pkg.sv
// Shared register indices and field positions for the real-time clock core.
// Assumes a flat register space of at most eight entries.
package rtc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_SECONDS = 3'd0,
        RA_ALARM   = 3'd1,
        RA_CALIB   = 3'd2,
        RA_CTRL    = 3'd3,
        RA_STATUS  = 3'd4,
        RA_STEP    = 3'd5
    } rtc_reg_e;

    localparam int CTL_SEC_EN  = 0;
    localparam int CTL_ALM_EN  = 1;
    localparam int CTL_TEST    = 2;

    localparam int ST_SEC      = 0;
    localparam int ST_ALM      = 1;
    localparam int N_SOURCES   = 2;
endpackage

// File: rtl/rtc_tick_gen.sv
// Tick divider with fractional trim. It counts accepted ticks and emits a
// one-cycle strobe on the tick that completes a second. The second lasts
// INT+1 ticks, plus one more tick when the window index is below the
// fractional field. Assumes tick_en is at most one cycle wide per tick.
module rtc_tick_gen #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              restart,
    input  logic [INT_W-1:0]  int_len,
    input  logic [FRAC_W-1:0] frac_n,
    output logic              sec_stb
);
    localparam int CNT_W = INT_W + 1;

    logic [CNT_W-1:0]  cnt;
    logic [FRAC_W-1:0] win_idx;
    logic              stretch;
    logic [CNT_W-1:0]  limit;

    // Choose this second's length from the window index and the trim field.
    always_comb begin
        stretch = (win_idx < frac_n);
        limit   = {1'b0, int_len} + CNT_W'(stretch);
        sec_stb = tick_en && !restart && (cnt >= limit);
    end

    // Advance the tick count and the window index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            win_idx <= '0;
        end else if (restart) begin
            cnt     <= '0;
            win_idx <= '0;
        end else if (tick_en) begin
            if (sec_stb) begin
                cnt     <= '0;
                win_idx <= win_idx + 1'b1;
            end else begin
                cnt     <= cnt + 1'b1;
            end
        end
    end

    // R4: a restart clears both counters by the next edge.
    a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0) && (win_idx == '0));

    // R1: the count holds or steps by one, or returns to zero after a strobe.
    a_r1_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt == '0));

    // R3: the window index moves only when a second completes.
    a_r3_index_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !sec_stb) |=> $stable(win_idx));
endmodule

// File: rtl/rtc_sec_counter.sv
// Seconds counter with load and alarm detection. It increments on each
// second strobe. A load takes priority over the strobe. The alarm hit is a
// one-cycle pulse when an increment lands on the alarm value.
module rtc_sec_counter #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    input  logic             sec_stb,
    input  logic [SEC_W-1:0] alarm_val,
    output logic [SEC_W-1:0] seconds,
    output logic             alarm_hit
);
    logic [SEC_W-1:0] sec_next;

    // Compute the incremented value and compare it with the alarm.
    always_comb begin
        sec_next  = seconds + 1'b1;
        alarm_hit = sec_stb && !load && (sec_next == alarm_val);
    end

    // Hold, load or step the seconds count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seconds <= '0;
        else if (load)
            seconds <= load_val;
        else if (sec_stb)
            seconds <= sec_next;
    end

    // R2: a load is visible on the next edge.
    a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> seconds == $past(load_val));

    // R2: without a load the count never moves by more than one.
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (seconds == $past(seconds)) || (seconds == $past(seconds) + 1'b1));

    // R7: an alarm hit makes the count equal the alarm value.
    a_r7_hit_matches: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> seconds == $past(alarm_val));
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Sticky interrupt status with per-source enables. A set takes priority
// over a write-one clear in the same cycle. irq is the OR of enabled bits.
module rtc_irq_ctrl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] status,
    output logic         irq
);
    // Update each sticky status bit.
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n)
                status[i] <= 1'b0;
            else if (set[i])
                status[i] <= 1'b1;
            else if (clr[i])
                status[i] <= 1'b0;
        end

        // R5: a set source is held until it is cleared.
        a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr[i]) |=> status[i]);

        // R5: a set always lands, even against a clear.
        a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> status[i]);
    end

    // Combine the enabled sources into the interrupt line.
    always_comb irq = |(status & en);
endmodule

// File: rtl/rtc_core.sv
// Real-time clock top. It holds the software registers, picks the tick
// source (crystal pulse, or the step register in test mode), and connects
// the tick divider, seconds counter and interrupt logic. Reads are
// combinational. Writes take effect at the next rising edge.
module rtc_core
    import rtc_pkg::*;
#(
    parameter int SEC_W   = 32,
    parameter int INT_W   = 16,
    parameter int FRAC_W  = 4,
    parameter int INT_RST = 32767
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [SEC_W-1:0]  reg_wdata,
    output logic [SEC_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int FRAC_LO = INT_W;
    localparam int FRAC_HI = INT_W + FRAC_W - 1;
    localparam int CTL_W   = 3;

    logic [SEC_W-1:0]     alarm_q;
    logic [INT_W-1:0]     cal_int_q;
    logic [FRAC_W-1:0]    cal_frac_q;
    logic [CTL_W-1:0]     ctrl_q;
    logic [SEC_W-1:0]     seconds;
    logic [N_SOURCES-1:0] status, st_set, st_clr;
    logic                 wr_sec, wr_alarm, wr_cal, wr_ctrl, wr_stat, wr_step;
    logic                 tick_en, sec_stb, alarm_hit;

    // Decode register writes.
    always_comb begin
        wr_sec   = reg_wr && (reg_addr == RA_SECONDS);
        wr_alarm = reg_wr && (reg_addr == RA_ALARM);
        wr_cal   = reg_wr && (reg_addr == RA_CALIB);
        wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
        wr_stat  = reg_wr && (reg_addr == RA_STATUS);
        wr_step  = reg_wr && (reg_addr == RA_STEP);
    end

    // Select the tick source: step writes in test mode, crystal otherwise.
    always_comb tick_en = ctrl_q[CTL_TEST] ? wr_step : xtal_tick;

    // Hold the alarm, calibration and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q    <= '0;
            cal_int_q  <= INT_W'(INT_RST);
            cal_frac_q <= '0;
            ctrl_q     <= '0;
        end else begin
            if (wr_alarm) alarm_q <= reg_wdata;
            if (wr_cal) begin
                cal_int_q  <= reg_wdata[INT_W-1:0];
                cal_frac_q <= reg_wdata[FRAC_HI:FRAC_LO];
            end
            if (wr_ctrl) ctrl_q <= reg_wdata[CTL_W-1:0];
        end
    end

    rtc_tick_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(wr_sec),
        .int_len(cal_int_q), .frac_n(cal_frac_q), .sec_stb(sec_stb)
    );

    rtc_sec_counter #(.SEC_W(SEC_W)) u_sec (
        .clk(clk), .rst_n(rst_n), .load(wr_sec), .load_val(reg_wdata),
        .sec_stb(sec_stb), .alarm_val(alarm_q), .seconds(seconds),
        .alarm_hit(alarm_hit)
    );

    // Map events and write-one clears onto the status sources.
    always_comb begin
        st_set          = '0;
        st_set[ST_SEC]  = sec_stb;
        st_set[ST_ALM]  = alarm_hit;
        st_clr          = wr_stat ? reg_wdata[N_SOURCES-1:0] : '0;
    end

    rtc_irq_ctrl #(.N(N_SOURCES)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(st_set), .clr(st_clr),
        .en(ctrl_q[N_SOURCES-1:0]), .status(status), .irq(irq)
    );

    // Return the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_SECONDS: reg_rdata = seconds;
            RA_ALARM:   reg_rdata = alarm_q;
            RA_CALIB:   begin
                reg_rdata[INT_W-1:0]       = cal_int_q;
                reg_rdata[FRAC_HI:FRAC_LO] = cal_frac_q;
            end
            RA_CTRL:    reg_rdata[CTL_W-1:0]     = ctrl_q;
            RA_STATUS:  reg_rdata[N_SOURCES-1:0] = status;
            default:    reg_rdata = '0;
        endcase
    end

    // R8: in test mode the crystal pulse alone never advances the seconds.
    a_r8_xtal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTL_TEST] && !reg_wr) |=> $stable(seconds));

    // R6: irq is never raised without an enabled source.
    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> |ctrl_q[N_SOURCES-1:0]);
endmodule

// File: tb/rtc_core_tb.sv
// Self-checking bench for rtc_core. It sweeps every fractional trim value
// over a full 16-second window with a short integer period.
module rtc_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    rtc_core u_dut (.clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .reg_wr(reg_wr),
                    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
                    .irq(irq));

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 3'd0;
    endtask

    task automatic tick();
        @(negedge clk);
        xtal_tick = 1'b1;
        @(negedge clk);
        xtal_tick = 1'b0;
    endtask

    task automatic ticks_to_change(output int n);
        logic [31:0] s0, s1;
        rd(3'd0, s0);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            tick();
            n++;
            rd(3'd0, s1);
            if (s1 != s0) break;
        end
    endtask

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        rd(3'd0, v); check("R9 seconds reset", v, 32'd0);
        rd(3'd1, v); check("R9 alarm reset", v, 32'd0);
        rd(3'd2, v); check("R9 calib reset", v, 32'd32767);
        rd(3'd3, v); check("R9 ctrl reset", v, 32'd0);
        rd(3'd4, v); check("R9 status reset", v, 32'd0);
        check("R6 irq reset", {31'd0, irq}, 32'd0);

        // R1 nominal period with I=2
        wr(3'd2, 32'd2);
        rd(3'd2, v); check("R9 calib readback", v, 32'd2);
        wr(3'd0, 32'd0);
        for (int s = 0; s < 4; s++) begin
            ticks_to_change(n); check("R1 ticks per second", n, 32'd3);
        end
        rd(3'd0, v); check("R1 seconds value", v, 32'd4);

        // R5 and R6 status and interrupt behaviour
        rd(3'd4, v); check("R5 second status sticky", v & 32'h1, 32'h1);
        check("R6 irq masked", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'h1);
        rd(3'd3, v); check("R9 ctrl readback", v, 32'h1);
        check("R6 irq enabled", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'h1);
        rd(3'd4, v); check("R5 write-one clear", v & 32'h1, 32'h0);
        check("R6 irq after clear", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'h0);

        // R3 full sweep of the fractional field
        for (int f = 0; f < 16; f++) begin
            wr(3'd2, (32'(f) << 16) | 32'd2);
            wr(3'd0, 32'd0);
            for (int k = 0; k < 17; k++) begin
                ticks_to_change(n);
                check("R3 trimmed period", n, ((k % 16) < f) ? 32'd4 : 32'd3);
            end
        end
        wr(3'd2, 32'd2);

        // R4 load restarts the divider
        wr(3'd0, 32'd100);
        tick(); tick();
        wr(3'd0, 32'd200);
        rd(3'd0, v); check("R2 load value", v, 32'd200);
        tick(); tick();
        rd(3'd0, v); check("R4 no early second", v, 32'd200);
        tick();
        rd(3'd0, v); check("R4 full period after load", v, 32'd201);

        // R2 wrap
        wr(3'd0, 32'hFFFF_FFFF);
        ticks_to_change(n); check("R2 wrap period", n, 32'd3);
        rd(3'd0, v); check("R2 wrap to zero", v, 32'd0);

        // R7 alarm
        wr(3'd4, 32'h3);
        wr(3'd3, 32'h2);
        wr(3'd1, 32'd5);
        rd(3'd1, v); check("R9 alarm readback", v, 32'd5);
        wr(3'd0, 32'd5);
        rd(3'd4, v); check("R7 load does not fire", v & 32'h2, 32'h0);
        wr(3'd0, 32'd3);
        ticks_to_change(n);
        rd(3'd4, v); check("R7 not yet at 4", v & 32'h2, 32'h0);
        check("R6 irq quiet before alarm", {31'd0, irq}, 32'd0);
        ticks_to_change(n);
        rd(3'd4, v); check("R7 alarm at 5", v & 32'h2, 32'h2);
        check("R6 irq on alarm", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'h2);
        check("R6 irq after alarm clear", {31'd0, irq}, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd0, 32'hFFFF_FFFF);
        ticks_to_change(n);
        rd(3'd4, v); check("R7 alarm at wrap", v & 32'h2, 32'h2);
        wr(3'd4, 32'h3);
        wr(3'd3, 32'h0);

        // R8 step register ignored outside test mode
        wr(3'd0, 32'd0);
        wr(3'd5, 32'd0); wr(3'd5, 32'd0);
        tick(); tick();
        rd(3'd0, v); check("R8 step ignored in normal mode", v, 32'd0);
        tick();
        rd(3'd0, v); check("R8 crystal still counts", v, 32'd1);

        // R8 test mode: crystal ignored, one tick per step write
        wr(3'd3, 32'h4);
        wr(3'd0, 32'd0);
        for (int k = 0; k < 5; k++) tick();
        rd(3'd0, v); check("R8 crystal ignored in test", v, 32'd0);
        wr(3'd5, 32'd0); wr(3'd5, 32'd0);
        rd(3'd0, v); check("R8 two steps", v, 32'd0);
        wr(3'd5, 32'd0);
        rd(3'd0, v); check("R8 third step completes second", v, 32'd1);
        for (int k = 0; k < 6; k++) wr(3'd5, 32'd0);
        rd(3'd0, v); check("R8 six steps two seconds", v, 32'd3);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule